// File: doc/BRIEF.md
# TCP Session Sequencer

This block steers one TCP session from power-up to teardown. Once reset is released it learns the peer's MAC address in one of three ways. It then waits in idle for a user command. It carries the session through an active or passive open, a data phase, and an active or passive close, and it returns to idle afterwards.

The sequencer does not format packets. It asks a separate packet builder for each frame with a one-cycle request on a one-hot vector. It learns what arrived from one-cycle event strobes raised by a receive decoder. A per-state timeout, counted in clock cycles and latched at reset release, drives retransmission. Each state has its own retry limit and its own fallback frame. Every timeout, and every reset frame received during the data phase, raises a one-cycle interrupt together with a one-hot cause vector.

Top module: `tcp_session_ctrl`

## Requirements
- R1: While `rst_n` is low, `state_code` is 00000, `init_done` and `conn_on` are 0, and `pkt_req` and `irq_cause` are zero. `mac_mode`, `fixed_peer_mac` and `timeout_cycles` are captured on every clock edge with `rst_n` low and are frozen after release.
- R2: State codes are fixed: 00000 reset, 00001 init, 00010 idle, 00011 active open, 00100 passive open, 00101 port active, 00110 active close, 00111 passive close, 01000 TCP reset, 11111 error. With `mac_mode` = 1x, the first edge after release enters init without any request. The next edge enters idle, sets `init_done`, and drives `peer_mac` with `fixed_peer_mac`.
- R3: With `mac_mode` = 00, init entry issues an ARP request (`pkt_req` bit 0). Each timeout in init reissues it and raises `irq_cause` bit 0. `rx_arp_rep` moves to idle, captures `rx_peer_mac` and sets `init_done`.
- R4: With `mac_mode` = 01, init sends nothing and never times out. `rx_arp_req` captures `rx_peer_mac`, issues an ARP reply (`pkt_req` bit 1) and moves to idle.
- R5: `cmd_code` 01 is active open, 1x is passive open and 00 is active close. Opens are accepted only in idle and close only in port active. Any other strobed command leaves the state and `pkt_req` unchanged.
- R6: Active open issues SYN (bit 2). `rx_synack` issues ACK (bit 4) and enters port active. Timeouts resend SYN up to 16 times, each with cause bit 1. The 17th timeout issues FIN (bit 7), also with cause bit 1, and returns to idle.
- R7: Passive open waits for `rx_syn` without a timeout, then issues SYN|ACK (bit 3). `rx_ack` enters port active. Timeouts resend SYN|ACK up to 16 times with cause bit 2, and the 17th timeout issues FIN and returns to idle.
- R8: Active close issues FIN|ACK (bit 5). `rx_finack` issues ACK and returns to idle. A timeout issues RST (bit 6) with cause bit 3 and enters TCP reset, which leads to idle on the next edge.
- R9: In port active, `rx_finack` enters passive close and issues FIN|ACK. `rx_ack` returns to idle. Timeouts resend FIN|ACK up to 16 times with cause bit 4, and the 17th timeout issues RST and enters TCP reset.
- R10: In port active, `rx_rst` returns to idle with no request and raises cause bit 9. It takes priority over `rx_finack` and over a close command.
- R11: A retransmission or fallback frame appears exactly `timeout_cycles` (latched value) cycles after the previous request or state entry. The timeout reloads on every state change and every request.
- R12: `user_tx_err` in any state other than reset enters the error state, which ignores all events and commands until `rst_n` is asserted.
- R13: At most one `pkt_req` bit and at most one `irq_cause` bit are set in a cycle. `tmo_irq` is high exactly in cycles where `irq_cause` is nonzero. `conn_on` is high in port active, active close and passive close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mac_mode | input | 2 | Peer MAC acquisition mode |
| fixed_peer_mac | input | 48 | Peer MAC for fixed mode |
| timeout_cycles | input | 32 | Timeout in clock cycles (1 or more) |
| cmd_code | input | 2 | User command code |
| cmd_strobe | input | 1 | One-cycle command strobe |
| user_tx_err | input | 1 | User transmit error flag |
| rx_arp_req | input | 1 | ARP request received |
| rx_arp_rep | input | 1 | ARP reply received |
| rx_peer_mac | input | 48 | Sender MAC of received ARP frame |
| rx_syn | input | 1 | SYN received |
| rx_synack | input | 1 | SYN with ACK received |
| rx_ack | input | 1 | ACK received |
| rx_finack | input | 1 | FIN with ACK received |
| rx_rst | input | 1 | RST received |
| state_code | output | 5 | Current state code |
| init_done | output | 1 | Peer MAC acquired |
| conn_on | output | 1 | Connection established |
| peer_mac | output | 48 | Acquired peer MAC |
| pkt_req | output | 8 | One-hot packet builder request |
| tmo_irq | output | 1 | One-cycle interrupt |
| irq_cause | output | 16 | One-hot interrupt cause, valid with tmo_irq |

## Verification
The embedded properties watch the cycle-level invariants on every clock. Requests and causes stay one-hot, and the error state is sticky. An active open can only be entered from idle. A received reset in port active leaves silently to idle. The retry counter never passes its limit or advances once spent. No timeout fires in the cycle after a reload with a value above one, and ARP frames never appear in fixed mode. Exact retransmission spacing, the count of 16 resends before each fallback frame, the different fallbacks per state, and the latched timeout and MAC values can only be shown by the bench's scenarios, which use randomized retry counts and timeout values.

// File: rtl/tcp_sess_pkg.sv
package tcp_sess_pkg;

  typedef enum logic [4:0] {
    ST_RESET  = 5'b00000,
    ST_INIT   = 5'b00001,
    ST_IDLE   = 5'b00010,
    ST_AOPEN  = 5'b00011,
    ST_POPEN  = 5'b00100,
    ST_ACTIVE = 5'b00101,
    ST_ACLOSE = 5'b00110,
    ST_PCLOSE = 5'b00111,
    ST_TRST   = 5'b01000,
    ST_ERR    = 5'b11111
  } sess_state_e;

  localparam int PKT_W = 8;
  localparam int PK_ARP_REQ = 0;
  localparam int PK_ARP_REP = 1;
  localparam int PK_SYN     = 2;
  localparam int PK_SYNACK  = 3;
  localparam int PK_ACK     = 4;
  localparam int PK_FINACK  = 5;
  localparam int PK_RST     = 6;
  localparam int PK_FIN     = 7;

  localparam int CS_ARP    = 0;
  localparam int CS_AOPEN  = 1;
  localparam int CS_POPEN  = 2;
  localparam int CS_ACLOSE = 3;
  localparam int CS_PCLOSE = 4;
  localparam int CS_RSTRX  = 9;

  localparam logic [1:0] CMD_ACLOSE = 2'b00;
  localparam logic [1:0] CMD_AOPEN  = 2'b01;

  // connection considered up while a close is still in progress
  function automatic logic link_up(sess_state_e s);
    return (s == ST_ACTIVE) || (s == ST_ACLOSE) || (s == ST_PCLOSE);
  endfunction

  // a timeout count of zero behaves as one
  function automatic logic tmo_hit(logic [31:0] cnt);
    return cnt <= 32'd1;
  endfunction

endpackage

// File: rtl/sess_timer.sv
module sess_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] load_val,
  input  logic          reload,
  output logic          expire
);
  import tcp_sess_pkg::*;

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (reload)         cnt <= load_val;
    else if (cnt > TW'(1))   cnt <= cnt - TW'(1);
  end

  assign expire = tmo_hit(32'(cnt));

  // R11: a reload above one cannot expire on the very next cycle
  a_r11_no_early_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && load_val > TW'(1)) |=> !expire);

endmodule

// File: rtl/sess_retry.sv
module sess_retry #(
  parameter int MAX_RETRY = 16,
  localparam int RW = $clog2(MAX_RETRY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic spent
);
  logic [RW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) count <= '0;
    else if (bump)       count <= count + RW'(1);
  end

  assign spent = (count >= RW'(MAX_RETRY));

  // R6: the resend counter never passes its limit
  a_r6_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= RW'(MAX_RETRY));
  // R6: no resend is requested once the budget is used
  a_r6_bump_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bump |-> !spent);

endmodule

// File: rtl/sess_fsm.sv
module sess_fsm #(
  parameter int MAC_W   = 48,
  parameter int CAUSE_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    cfg_mode,
  input  logic [MAC_W-1:0]              cfg_mac,
  input  logic [1:0]                    cmd_code,
  input  logic                          cmd_strobe,
  input  logic                          user_tx_err,
  input  logic                          ev_arp_req,
  input  logic                          ev_arp_rep,
  input  logic [MAC_W-1:0]              ev_mac,
  input  logic                          ev_syn,
  input  logic                          ev_synack,
  input  logic                          ev_ack,
  input  logic                          ev_finack,
  input  logic                          ev_rst,
  input  logic                          expire,
  input  logic                          spent,
  output tcp_sess_pkg::sess_state_e     state,
  output logic [tcp_sess_pkg::PKT_W-1:0] tx_req,
  output logic [CAUSE_W-1:0]            irq_status,
  output logic                          init_done,
  output logic [MAC_W-1:0]              peer_mac,
  output logic                          reload,
  output logic                          retry_bump,
  output logic                          retry_clear
);
  import tcp_sess_pkg::*;

  sess_state_e       nxt;
  logic [PKT_W-1:0]  send;
  logic [CAUSE_W-1:0] cause;
  logic              take_mac;
  logic [MAC_W-1:0]  mac_src;
  logic              sa_sent, sa_nxt;

  always_comb begin
    nxt        = state;
    send       = '0;
    cause      = '0;
    retry_bump = 1'b0;
    take_mac   = 1'b0;
    mac_src    = ev_mac;
    sa_nxt     = sa_sent;
    case (state)
      ST_RESET: begin
        nxt = ST_INIT;
        if (cfg_mode == 2'b00) send[PK_ARP_REQ] = 1'b1;
      end
      ST_INIT: begin
        if (cfg_mode[1]) begin
          nxt = ST_IDLE; take_mac = 1'b1; mac_src = cfg_mac;
        end else if (cfg_mode[0]) begin
          if (ev_arp_req) begin
            nxt = ST_IDLE; take_mac = 1'b1; send[PK_ARP_REP] = 1'b1;
          end
        end else begin
          if (ev_arp_rep) begin
            nxt = ST_IDLE; take_mac = 1'b1;
          end else if (expire) begin
            send[PK_ARP_REQ] = 1'b1; cause[CS_ARP] = 1'b1;
          end
        end
      end
      ST_IDLE: begin
        sa_nxt = 1'b0;
        if (cmd_strobe) begin
          if (cmd_code == CMD_AOPEN) begin
            nxt = ST_AOPEN; send[PK_SYN] = 1'b1;
          end else if (cmd_code[1]) begin
            nxt = ST_POPEN;
          end
        end
      end
      ST_AOPEN: begin
        if (ev_synack) begin
          nxt = ST_ACTIVE; send[PK_ACK] = 1'b1;
        end else if (expire) begin
          cause[CS_AOPEN] = 1'b1;
          if (spent) begin nxt = ST_IDLE; send[PK_FIN] = 1'b1; end
          else begin send[PK_SYN] = 1'b1; retry_bump = 1'b1; end
        end
      end
      ST_POPEN: begin
        if (!sa_sent) begin
          if (ev_syn) begin send[PK_SYNACK] = 1'b1; sa_nxt = 1'b1; end
        end else if (ev_ack) begin
          nxt = ST_ACTIVE;
        end else if (expire) begin
          cause[CS_POPEN] = 1'b1;
          if (spent) begin nxt = ST_IDLE; send[PK_FIN] = 1'b1; end
          else begin send[PK_SYNACK] = 1'b1; retry_bump = 1'b1; end
        end
      end
      ST_ACTIVE: begin
        if (ev_rst) begin
          nxt = ST_IDLE; cause[CS_RSTRX] = 1'b1;
        end else if (ev_finack) begin
          nxt = ST_PCLOSE; send[PK_FINACK] = 1'b1;
        end else if (cmd_strobe && cmd_code == CMD_ACLOSE) begin
          nxt = ST_ACLOSE; send[PK_FINACK] = 1'b1;
        end
      end
      ST_ACLOSE: begin
        if (ev_finack) begin
          nxt = ST_IDLE; send[PK_ACK] = 1'b1;
        end else if (expire) begin
          nxt = ST_TRST; send[PK_RST] = 1'b1; cause[CS_ACLOSE] = 1'b1;
        end
      end
      ST_PCLOSE: begin
        if (ev_ack) begin
          nxt = ST_IDLE;
        end else if (expire) begin
          cause[CS_PCLOSE] = 1'b1;
          if (spent) begin nxt = ST_TRST; send[PK_RST] = 1'b1; end
          else begin send[PK_FINACK] = 1'b1; retry_bump = 1'b1; end
        end
      end
      ST_TRST: nxt = ST_IDLE;
      ST_ERR:  nxt = ST_ERR;
      default: nxt = ST_ERR;
    endcase
    if (user_tx_err && state != ST_RESET && state != ST_ERR) begin
      nxt        = ST_ERR;
      send       = '0;
      cause      = '0;
      retry_bump = 1'b0;
      take_mac   = 1'b0;
    end
  end

  assign reload      = (nxt != state) || (send != '0);
  assign retry_clear = (nxt == ST_IDLE) || (nxt == ST_ACTIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_RESET;
      tx_req     <= '0;
      irq_status <= '0;
      init_done  <= 1'b0;
      peer_mac   <= '0;
      sa_sent    <= 1'b0;
    end else begin
      state      <= nxt;
      tx_req     <= send;
      irq_status <= cause;
      sa_sent    <= (nxt == ST_POPEN) ? sa_nxt : 1'b0;
      if (take_mac) peer_mac <= mac_src;
      if (state == ST_INIT && nxt == ST_IDLE) init_done <= 1'b1;
    end
  end

  // R1: reset drives the reset state with no requests
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (state == ST_RESET && tx_req == '0));
  // R13: one packet request and one cause at a time
  a_r13_single_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_req));
  a_r13_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_status));
  // R12: error is left only through reset
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERR) |=> (state == ST_ERR));
  // R5: active open is reached only from idle
  a_r5_open_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AOPEN && $past(state) != ST_AOPEN) |-> ($past(state) == ST_IDLE));
  // R10: a received reset in port active leaves silently
  a_r10_rst_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && ev_rst && !user_tx_err) |=>
      (state == ST_IDLE && tx_req == '0 && irq_status[CS_RSTRX]));
  // R2: fixed MAC mode never emits ARP frames
  a_r2_fixed_no_arp: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode[1] |-> (!tx_req[PK_ARP_REQ] && !tx_req[PK_ARP_REP]));
  // R6: FIN is only issued on the way back to idle
  a_r6_fin_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req[PK_FIN] |-> (state == ST_IDLE));

endmodule

// File: rtl/tcp_session_ctrl.sv
module tcp_session_ctrl #(
  parameter int MAC_W     = 48,
  parameter int TMO_W     = 32,
  parameter int MAX_RETRY = 16,
  parameter int CAUSE_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mac_mode,
  input  logic [MAC_W-1:0]   fixed_peer_mac,
  input  logic [TMO_W-1:0]   timeout_cycles,
  input  logic [1:0]         cmd_code,
  input  logic               cmd_strobe,
  input  logic               user_tx_err,
  input  logic               rx_arp_req,
  input  logic               rx_arp_rep,
  input  logic [MAC_W-1:0]   rx_peer_mac,
  input  logic               rx_syn,
  input  logic               rx_synack,
  input  logic               rx_ack,
  input  logic               rx_finack,
  input  logic               rx_rst,
  output logic [4:0]         state_code,
  output logic               init_done,
  output logic               conn_on,
  output logic [MAC_W-1:0]   peer_mac,
  output logic [7:0]         pkt_req,
  output logic               tmo_irq,
  output logic [CAUSE_W-1:0] irq_cause
);
  import tcp_sess_pkg::*;

  logic [1:0]       cfg_mode;
  logic [MAC_W-1:0] cfg_mac;
  logic [TMO_W-1:0] cfg_tmo;

  // settings follow the inputs while reset is held, then freeze
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode <= mac_mode;
      cfg_mac  <= fixed_peer_mac;
      cfg_tmo  <= timeout_cycles;
    end
  end

  sess_state_e      state;
  logic             expire, spent, reload, retry_bump, retry_clear;
  logic [PKT_W-1:0] tx_req;

  sess_timer #(.TW(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_val(cfg_tmo), .reload(reload), .expire(expire)
  );

  sess_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk(clk), .rst_n(rst_n), .clear(retry_clear), .bump(retry_bump), .spent(spent)
  );

  sess_fsm #(.MAC_W(MAC_W), .CAUSE_W(CAUSE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_mac(cfg_mac),
    .cmd_code(cmd_code), .cmd_strobe(cmd_strobe), .user_tx_err(user_tx_err),
    .ev_arp_req(rx_arp_req), .ev_arp_rep(rx_arp_rep), .ev_mac(rx_peer_mac),
    .ev_syn(rx_syn), .ev_synack(rx_synack), .ev_ack(rx_ack),
    .ev_finack(rx_finack), .ev_rst(rx_rst),
    .expire(expire), .spent(spent),
    .state(state), .tx_req(tx_req), .irq_status(irq_cause),
    .init_done(init_done), .peer_mac(peer_mac),
    .reload(reload), .retry_bump(retry_bump), .retry_clear(retry_clear)
  );

  assign state_code = state;
  assign pkt_req    = tx_req;
  assign tmo_irq    = |irq_cause;
  assign conn_on    = link_up(state);

  // R13: interrupt pulses exactly with a cause
  a_r13_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq == (irq_cause != '0));

endmodule

// File: tb/tcp_session_ctrl_tb.sv
module tcp_session_ctrl_tb;

  localparam logic [4:0] S_RESET = 5'd0, S_INIT = 5'd1, S_IDLE = 5'd2, S_AOPEN = 5'd3,
                         S_POPEN = 5'd4, S_ACTIVE = 5'd5, S_ACLOSE = 5'd6, S_PCLOSE = 5'd7,
                         S_TRST = 5'd8, S_ERR = 5'd31;
  localparam int B_ARPQ = 0, B_ARPP = 1, B_SYN = 2, B_SYNACK = 3, B_ACK = 4,
                 B_FINACK = 5, B_RST = 6, B_FIN = 7;
  localparam int E_ARPQ = 0, E_ARPP = 1, E_SYN = 2, E_SYNACK = 3, E_ACK = 4,
                 E_FINACK = 5, E_RST = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mac_mode = 2'b10;
  logic [47:0] fixed_peer_mac = '0;
  logic [31:0] timeout_cycles = 32'd4;
  logic [1:0]  cmd_code = 2'b00;
  logic        cmd_strobe = 1'b0;
  logic        user_tx_err = 1'b0;
  logic [6:0]  ev = '0;
  logic [47:0] rx_peer_mac = '0;
  logic [4:0]  state_code;
  logic        init_done, conn_on, tmo_irq;
  logic [47:0] peer_mac;
  logic [7:0]  pkt_req;
  logic [15:0] irq_cause;

  int tests = 0, fails = 0;
  int tmo = 4;
  bit multi_pkt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tcp_session_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mac_mode(mac_mode), .fixed_peer_mac(fixed_peer_mac),
    .timeout_cycles(timeout_cycles), .cmd_code(cmd_code), .cmd_strobe(cmd_strobe),
    .user_tx_err(user_tx_err), .rx_arp_req(ev[E_ARPQ]), .rx_arp_rep(ev[E_ARPP]),
    .rx_peer_mac(rx_peer_mac), .rx_syn(ev[E_SYN]), .rx_synack(ev[E_SYNACK]),
    .rx_ack(ev[E_ACK]), .rx_finack(ev[E_FINACK]), .rx_rst(ev[E_RST]),
    .state_code(state_code), .init_done(init_done), .conn_on(conn_on),
    .peer_mac(peer_mac), .pkt_req(pkt_req), .tmo_irq(tmo_irq), .irq_cause(irq_cause)
  );

  // R13 monitor: more than one request bit in any cycle
  always @(negedge clk) if (rst_n && $countones(pkt_req) > 1) multi_pkt = 1;

  function automatic logic [7:0] bit8(int i);  return 8'(1) << i;  endfunction
  function automatic logic [15:0] bit16(int i); return 16'(1) << i; endfunction
  function automatic int resend_limit(logic [4:0] s); return (s == S_ACLOSE) ? 0 : 16; endfunction
  function automatic int resend_pkt(logic [4:0] s);
    return (s == S_AOPEN) ? B_SYN : (s == S_POPEN) ? B_SYNACK : B_FINACK;
  endfunction
  function automatic int fallback_pkt(logic [4:0] s);
    return (s == S_AOPEN || s == S_POPEN) ? B_FIN : B_RST;
  endfunction
  function automatic logic [4:0] fallback_state(logic [4:0] s);
    return (fallback_pkt(s) == B_FIN) ? S_IDLE : S_TRST;
  endfunction
  function automatic int cause_bit(logic [4:0] s);
    case (s)
      S_AOPEN: return 1;  S_POPEN: return 2;
      S_ACLOSE: return 3; default: return 4;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic pulse_cmd(logic [1:0] c);
    cmd_code = c; cmd_strobe = 1'b1; step(); cmd_strobe = 1'b0;
  endtask

  task automatic pulse_ev(int e);
    ev = 7'(1) << e; step(); ev = '0;
  endtask

  // n cycles: silence until the last, where pkt is expected
  task automatic expect_send_after(int n, logic [7:0] pkt, string tag);
    bit quiet = 1;
    for (int i = 1; i < n; i++) begin
      step();
      if (pkt_req != 0) quiet = 0;
    end
    step();
    check(quiet && pkt_req == pkt, tag, {quiet, pkt_req}, {1'b1, pkt});
  endtask

  task automatic expect_quiet(int n, string tag);
    bit quiet = 1;
    for (int i = 0; i < n; i++) begin
      step();
      if (pkt_req != 0 || tmo_irq) quiet = 0;
    end
    check(quiet, tag, {7'd0, quiet}, 8'd1);
  endtask

  task automatic run_timeouts(logic [4:0] s, int n, string tag);
    for (int i = 0; i < n; i++) begin
      if (i < resend_limit(s)) begin
        expect_send_after(tmo, bit8(resend_pkt(s)), tag);
        check(tmo_irq && irq_cause == bit16(cause_bit(s)) && state_code == s, tag,
              {tmo_irq, irq_cause, state_code}, {1'b1, bit16(cause_bit(s)), s});
      end else begin
        expect_send_after(tmo, bit8(fallback_pkt(s)), tag);
        check(tmo_irq && irq_cause == bit16(cause_bit(s)) && state_code == fallback_state(s),
              tag, {tmo_irq, irq_cause, state_code},
              {1'b1, bit16(cause_bit(s)), fallback_state(s)});
      end
    end
  endtask

  task automatic do_reset(logic [1:0] mode, int t, logic [47:0] mac);
    rst_n = 1'b0; mac_mode = mode; timeout_cycles = 32'(t); fixed_peer_mac = mac;
    tmo = t;
    repeat (3) step();
    check(state_code == S_RESET && !init_done && !conn_on && pkt_req == 0 && irq_cause == 0,
          "R1 reset outputs", {state_code, init_done, conn_on, pkt_req}, {S_RESET, 10'd0});
    rst_n = 1'b1;
  endtask

  task automatic open_active();
    pulse_cmd(2'b01);
    check(state_code == S_AOPEN && pkt_req == bit8(B_SYN), "R6 SYN on open",
          {state_code, pkt_req}, {S_AOPEN, bit8(B_SYN)});
    pulse_ev(E_SYNACK);
    check(state_code == S_ACTIVE && pkt_req == bit8(B_ACK) && conn_on, "R6 ACK to active",
          {state_code, pkt_req, conn_on}, {S_ACTIVE, bit8(B_ACK), 1'b1});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    step();
    // fixed MAC mode; inputs change after release to prove latching
    do_reset(2'b10, 4, 48'h0A1B2C3D4E5F);
    step();
    timeout_cycles = 32'd100; fixed_peer_mac = 48'h111111111111; mac_mode = 2'b00;
    check(state_code == S_INIT && pkt_req == 0, "R2 init entry", {state_code, pkt_req}, {S_INIT, 8'd0});
    step();
    check(state_code == S_IDLE && init_done && peer_mac == 48'h0A1B2C3D4E5F && pkt_req == 0,
          "R2 fixed mac idle", {state_code, init_done, peer_mac}, {S_IDLE, 1'b1, 48'h0A1B2C3D4E5F});

    // R5: close in idle ignored
    pulse_cmd(2'b00);
    check(state_code == S_IDLE && pkt_req == 0, "R5 close ignored in idle",
          {state_code, pkt_req}, {S_IDLE, 8'd0});

    // R6 with random resend count, R11 spacing uses latched value 4
    begin
      int k = int'($urandom_range(16, 0));
      pulse_cmd(2'b01);
      check(state_code == S_AOPEN && pkt_req == bit8(B_SYN), "R6 SYN on open",
            {state_code, pkt_req}, {S_AOPEN, bit8(B_SYN)});
      run_timeouts(S_AOPEN, k, "R11 R6 SYN resend spacing");
      pulse_ev(E_SYNACK);
      check(state_code == S_ACTIVE && pkt_req == bit8(B_ACK) && conn_on, "R6 ACK to active",
            {state_code, pkt_req, conn_on}, {S_ACTIVE, bit8(B_ACK), 1'b1});
    end

    // R5: open in port active ignored
    pulse_cmd(2'b01);
    check(state_code == S_ACTIVE && pkt_req == 0, "R5 open ignored in active",
          {state_code, pkt_req}, {S_ACTIVE, 8'd0});

    // R9 passive close success
    pulse_ev(E_FINACK);
    check(state_code == S_PCLOSE && pkt_req == bit8(B_FINACK) && conn_on, "R9 enter passive close",
          {state_code, pkt_req, conn_on}, {S_PCLOSE, bit8(B_FINACK), 1'b1});
    pulse_ev(E_ACK);
    check(state_code == S_IDLE && pkt_req == 0 && !conn_on, "R9 ack to idle",
          {state_code, pkt_req, conn_on}, {S_IDLE, 9'd0});

    // R6 exhaustion: 16 resends then FIN
    pulse_cmd(2'b01);
    run_timeouts(S_AOPEN, 17, "R6 active open exhaustion");
    check(!conn_on, "R6 no connection after FIN", {63'd0, conn_on}, 64'd0);

    // R7 passive open with random resends
    begin
      int k = int'($urandom_range(5, 0));
      pulse_cmd(2'b11);
      check(state_code == S_POPEN && pkt_req == 0, "R7 passive open waits",
            {state_code, pkt_req}, {S_POPEN, 8'd0});
      expect_quiet(3 * tmo, "R7 no timeout waiting for SYN");
      pulse_ev(E_SYN);
      check(pkt_req == bit8(B_SYNACK) && state_code == S_POPEN, "R7 SYN|ACK answer",
            {state_code, pkt_req}, {S_POPEN, bit8(B_SYNACK)});
      run_timeouts(S_POPEN, k, "R7 SYN|ACK resend");
      pulse_ev(E_ACK);
      check(state_code == S_ACTIVE && pkt_req == 0, "R7 ack to active",
            {state_code, pkt_req}, {S_ACTIVE, 8'd0});
    end

    // R8 active close success
    pulse_cmd(2'b00);
    check(state_code == S_ACLOSE && pkt_req == bit8(B_FINACK) && conn_on, "R8 FIN|ACK on close",
          {state_code, pkt_req}, {S_ACLOSE, bit8(B_FINACK)});
    pulse_ev(E_FINACK);
    check(state_code == S_IDLE && pkt_req == bit8(B_ACK), "R8 ack to idle",
          {state_code, pkt_req}, {S_IDLE, bit8(B_ACK)});

    // R8 active close timeout
    open_active();
    pulse_cmd(2'b00);
    run_timeouts(S_ACLOSE, 1, "R8 close timeout RST");
    step();
    check(state_code == S_IDLE && pkt_req == 0, "R8 TCP reset to idle",
          {state_code, pkt_req}, {S_IDLE, 8'd0});

    // R9 passive close exhaustion
    open_active();
    pulse_ev(E_FINACK);
    run_timeouts(S_PCLOSE, 17, "R9 passive close exhaustion");
    step();
    check(state_code == S_IDLE, "R9 TCP reset to idle", {59'd0, state_code}, {59'd0, S_IDLE});

    // R10 reset received, with FIN|ACK and close in the same cycle
    open_active();
    ev = bit8(E_RST)[6:0] | bit8(E_FINACK)[6:0]; cmd_code = 2'b00; cmd_strobe = 1'b1;
    step(); ev = '0; cmd_strobe = 1'b0;
    check(state_code == S_IDLE && pkt_req == 0 && tmo_irq && irq_cause == bit16(9),
          "R10 silent close on RST", {state_code, pkt_req, irq_cause}, {S_IDLE, 8'd0, bit16(9)});

    // R12 error is sticky
    open_active();
    user_tx_err = 1'b1; step(); user_tx_err = 1'b0;
    check(state_code == S_ERR && pkt_req == 0, "R12 enter error", {state_code, pkt_req}, {S_ERR, 8'd0});
    pulse_ev(E_RST); pulse_ev(E_FINACK); pulse_cmd(2'b01);
    expect_quiet(10, "R12 error ignores input");
    check(state_code == S_ERR, "R12 still error", {59'd0, state_code}, {59'd0, S_ERR});

    // R3 auto-client mode with random timeout
    begin
      int t = int'($urandom_range(6, 1));
      int m = int'($urandom_range(3, 0));
      do_reset(2'b00, t, 48'h0);
      step();
      check(state_code == S_INIT && pkt_req == bit8(B_ARPQ), "R3 ARP request on init",
            {state_code, pkt_req}, {S_INIT, bit8(B_ARPQ)});
      for (int i = 0; i < m; i++) begin
        expect_send_after(tmo, bit8(B_ARPQ), "R3 ARP resend");
        check(tmo_irq && irq_cause == bit16(0), "R3 ARP timeout cause",
              {tmo_irq, irq_cause}, {1'b1, bit16(0)});
      end
      rx_peer_mac = 48'hCAFE00BEEF01;
      pulse_ev(E_ARPP);
      check(state_code == S_IDLE && init_done && peer_mac == 48'hCAFE00BEEF01 && pkt_req == 0,
            "R3 reply to idle", {state_code, init_done, peer_mac}, {S_IDLE, 1'b1, 48'hCAFE00BEEF01});
    end

    // R4 auto-server mode
    do_reset(2'b01, 3, 48'h0);
    step();
    check(state_code == S_INIT && pkt_req == 0, "R4 server init silent",
          {state_code, pkt_req}, {S_INIT, 8'd0});
    expect_quiet(12, "R4 no timeout in server init");
    rx_peer_mac = 48'h00DEADC0FFEE;
    pulse_ev(E_ARPQ);
    check(state_code == S_IDLE && pkt_req == bit8(B_ARPP) && peer_mac == 48'h00DEADC0FFEE && init_done,
          "R4 ARP reply", {state_code, pkt_req, peer_mac}, {S_IDLE, bit8(B_ARPP), 48'h00DEADC0FFEE});

    check(!multi_pkt, "R13 single request per cycle", {63'd0, multi_pkt}, 64'd0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule